// File: doc/BRIEF.md
# Command-Gated Serial Register Slave

This block is a four-wire serial slave that opens a small register file to an external bus master. The master selects the block with an active-low chip select. It clocks bits with a serial clock that idles high, drives data in on one line, and reads on a single output line. That output line carries register contents during a read and shows the data-ready state at all other times. A transfer always starts with a one-byte command. The command names the target register and the direction, and the data phase that follows is as wide as the register it names.

Conversion results enter from the core side through a valid/ready update port. A new word is held in a one-cycle stage. During that cycle the ready indication is forced to "not ready", and the word is then committed to the data register. The port stalls, with `upd_ready` low, for as long as any register is being shifted out. A producer must hold `upd_valid`, `upd_data` and `upd_chan` steady until it sees `upd_ready` high at a clock edge. A handshake accepts exactly one word. After one handshake `upd_ready` stays low for the next cycle.

In continuous-read mode, each new data word is shifted out without a command in front of it. A run of ones on the data input returns the interface to command phase. This lets a master recover from a lost bit count.

Top module: `sri_serial_regif`

## Requirements
- R1: After reset the block is in command phase and holds no unread word. With `cs_n` low, `dout_rdy` is high and `upd_ready` is high.
- R2: The command byte is sent MSB first and sampled on rising `sclk`. Bit 7 is 0 for a valid command. Bit 6 selects read (1) or write (0). Bits 5:3 give the address: 0 status, 1 mode, 2 configuration, 3 data. Bit 2 requests continuous read. A write to mode or configuration takes 24 data bits, MSB first. A later read returns those 24 bits MSB first, changing on falling `sclk`.
- R3: A command byte with bit 7 set is discarded. The next 8 bits are taken as a new command byte.
- R4: A word accepted on the update port makes `dout_rdy` low while the bus is idle. A data-register read (command 0x58) returns that word. `dout_rdy` returns high once the read's last bit is clocked. Each handshake is followed by a cycle with `upd_ready` low.
- R5: In the clock cycle right after an update handshake, `dout_rdy` is high even if an unread word was already waiting. It goes low one cycle later, when the new word is in place.
- R6: `upd_ready` is low from the decode of any read command until the last bit of that read has been clocked.
- R7: When mode bit 4 is set, a data read is 32 bits long: the 24-bit word followed by the status byte.
- R8: A status read (command 0x40) returns 8 bits. Bit 7 is 1 when no unread word is waiting. Bits 2:0 hold the channel tag of the latest word. All other bits are 0.
- R9: Command 0x5C reads the data register and enters continuous read. From then on, each newly committed word is shifted out with no command in front of it. If the byte 0x58 appears on the data input at a byte boundary of such a read, continuous read ends when that read completes.
- R10: Thirty-two consecutive ones sampled on `din` return the interface to command phase at bit 0, whatever transfer was in progress.
- R11: While `cs_n` is high, `dout_oe` is low and `sclk` edges have no effect on any register or transfer.
- R12: A write command aimed at status, data or addresses 4 to 7 transfers nothing, and the next 8 bits are a new command. A read of addresses 4 to 7 returns 8 zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle high |
| din | input | 1 | Serial data in, MSB first |
| dout_rdy | output | 1 | Serial data out during reads, ready indication otherwise (low = unread word) |
| dout_oe | output | 1 | High when the output line should be driven onto the bus |
| upd_valid | input | 1 | Update word offered |
| upd_data | input | 24 | Update word |
| upd_chan | input | 3 | Channel tag of the update word |
| upd_ready | output | 1 | Update port can accept a word this cycle |

## Verification
The state of the bit counter, the command byte and the phase is not visible directly. A fault there shows as misframed data. A register read back after a write comes out shifted or with wrong bits within one transfer. A command that should have been dropped swallows the next command, and the following read returns a wrong value. The ready path is checked cycle by cycle around each update handshake, because a wrong stage or flag shows on `dout_rdy` within one or two clock cycles. The continuous-read and ones-reset paths are each followed by a plain command. A phase left in the wrong state then corrupts the very next read.

// File: rtl/sri_pkg.sv
package sri_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_WR    = 2'd1,
    ST_RD    = 2'd2,
    ST_CWAIT = 2'd3
  } sri_state_e;

  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_CONF = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;

  typedef struct packed {
    logic       bad;
    logic       rd;
    logic [2:0] addr;
    logic       cont;
    logic [1:0] rsvd;
  } sri_cmd_t;

  function automatic sri_cmd_t sri_decode(input logic [CMD_W-1:0] b);
    sri_cmd_t c;
    c.bad  = b[7];
    c.rd   = b[6];
    c.addr = b[5:3];
    c.cont = b[2];
    c.rsvd = b[1:0];
    return c;
  endfunction

endpackage

// File: rtl/sri_sync.sv
module sri_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/sri_ones_guard.sv
module sri_ones_guard #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic bit_in,
  output logic hit
);

  localparam int CW = $clog2(LIMIT);

  logic [CW-1:0] run_q;

  assign hit = step && bit_in && (run_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (step) begin
      if (!bit_in || hit) run_q <= '0;
      else                run_q <= run_q + 1'b1;
    end
  end

endmodule

// File: rtl/sri_update_stage.sv
module sri_update_stage #(
  parameter int DATA_W = 24,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [DATA_W-1:0] upd_data,
  input  logic [CHAN_W-1:0] upd_chan,
  output logic              upd_ready,
  input  logic              hold,
  input  logic              consume,
  output logic [DATA_W-1:0] data_q,
  output logic [CHAN_W-1:0] chan_q,
  output logic              rdy_n
);

  logic              stage_q;
  logic              fresh_q;
  logic [DATA_W-1:0] pend_data;
  logic [CHAN_W-1:0] pend_chan;
  logic              accept;

  assign upd_ready = !hold && !stage_q;
  assign accept    = upd_valid && upd_ready;
  assign rdy_n     = !fresh_q || stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= 1'b0;
      fresh_q   <= 1'b0;
      pend_data <= '0;
      pend_chan <= '0;
      data_q    <= '0;
      chan_q    <= '0;
    end else begin
      stage_q <= accept;
      if (accept) begin
        pend_data <= upd_data;
        pend_chan <= upd_chan;
      end
      if (stage_q) begin
        data_q  <= pend_data;
        chan_q  <= pend_chan;
        fresh_q <= 1'b1;
      end else if (consume) begin
        fresh_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sri_serial_regif.sv
module sri_serial_regif
  import sri_pkg::*;
#(
  parameter int REG_W       = 24,
  parameter int CHAN_W      = 3,
  parameter int APPEND_BIT  = 4,
  parameter int RESET_ONES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout_rdy,
  output logic              dout_oe,
  input  logic              upd_valid,
  input  logic [REG_W-1:0]  upd_data,
  input  logic [CHAN_W-1:0] upd_chan,
  output logic              upd_ready
);

  localparam int STAT_W  = 8;
  localparam int FRAME_W = REG_W + STAT_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CMD_W-1:0] EXIT_CMD = {1'b0, 1'b1, A_DATA, 1'b0, 2'b00};

  // input conditioning
  logic cs_s, sclk_s, din_s, sclk_d;

  sri_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b111)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in ({cs_n, sclk, din}),
    .d_out({cs_s, sclk_s, din_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b1;
    else        sclk_d <= sclk_s;
  end

  logic act, rise, fall;
  assign act  = !cs_s;
  assign rise = act && sclk_s && !sclk_d;
  assign fall = act && !sclk_s && sclk_d;

  // state
  sri_state_e         st;
  logic [CNT_W-1:0]   bit_cnt;
  logic [CNT_W-1:0]   len_q;
  logic [CMD_W-1:0]   cmd_sr;
  logic [REG_W-1:0]   in_sr;
  logic [FRAME_W-1:0] out_sr;
  logic               out_bit;
  logic [2:0]         waddr;
  logic               rd_data;
  logic               cont_mode;
  logic [REG_W-1:0]   mode_q;
  logic [REG_W-1:0]   conf_q;

  // data register and ready flag
  logic [REG_W-1:0]  data_q;
  logic [CHAN_W-1:0] chan_q;
  logic              rdy_n;
  logic              hold;
  logic              consume;

  sri_update_stage #(
    .DATA_W(REG_W),
    .CHAN_W(CHAN_W)
  ) u_upd (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_valid(upd_valid),
    .upd_data (upd_data),
    .upd_chan (upd_chan),
    .upd_ready(upd_ready),
    .hold     (hold),
    .consume  (consume),
    .data_q   (data_q),
    .chan_q   (chan_q),
    .rdy_n    (rdy_n)
  );

  // ones-run resynchronisation
  logic hit;

  sri_ones_guard #(
    .LIMIT(RESET_ONES)
  ) u_guard (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (rise),
    .bit_in(din_s),
    .hit   (hit)
  );

  // command decode
  logic [CMD_W-1:0] cmd_byte;
  sri_cmd_t         dec;
  assign cmd_byte = {cmd_sr[CMD_W-2:0], din_s};
  assign dec      = sri_decode(cmd_byte);

  logic [STAT_W-1:0] stat_b;
  always_comb begin
    stat_b = '0;
    stat_b[STAT_W-1] = rdy_n;
    stat_b[CHAN_W-1:0] = chan_q;
  end

  logic               append;
  logic [2:0]         sel_addr;
  logic [FRAME_W-1:0] rd_word;
  logic [CNT_W-1:0]   rd_len;

  assign append   = mode_q[APPEND_BIT];
  assign sel_addr = (st == ST_CWAIT) ? A_DATA : dec.addr;

  always_comb begin
    rd_word = '0;
    rd_len  = CNT_W'(STAT_W);
    case (sel_addr)
      A_STAT: begin
        rd_word = {stat_b, {REG_W{1'b0}}};
        rd_len  = CNT_W'(STAT_W);
      end
      A_MODE: begin
        rd_word = {mode_q, {STAT_W{1'b0}}};
        rd_len  = CNT_W'(REG_W);
      end
      A_CONF: begin
        rd_word = {conf_q, {STAT_W{1'b0}}};
        rd_len  = CNT_W'(REG_W);
      end
      A_DATA: begin
        rd_word = append ? {data_q, stat_b} : {data_q, {STAT_W{1'b0}}};
        rd_len  = append ? CNT_W'(FRAME_W) : CNT_W'(REG_W);
      end
      default: begin
        rd_word = '0;
        rd_len  = CNT_W'(STAT_W);
      end
    endcase
  end

  logic cmd_done, start_rd, start_wr, cont_load;
  logic last_bit, rd_done, exit_now;
  logic [REG_W-1:0] wr_word;

  assign cmd_done  = rise && (st == ST_CMD) && (bit_cnt == CNT_W'(CMD_W - 1));
  assign start_rd  = cmd_done && !dec.bad && dec.rd;
  assign start_wr  = cmd_done && !dec.bad && !dec.rd &&
                     ((dec.addr == A_MODE) || (dec.addr == A_CONF));
  assign cont_load = (st == ST_CWAIT) && act && sclk_s && !rdy_n;
  assign last_bit  = rise && (bit_cnt == (len_q - CNT_W'(1)));
  assign rd_done   = (st == ST_RD) && last_bit;
  assign exit_now  = (st == ST_RD) && rise && cont_mode &&
                     (bit_cnt[2:0] == 3'd7) && (cmd_byte == EXIT_CMD);
  assign consume   = rd_done && rd_data;
  assign hold      = (st == ST_RD) || start_rd || cont_load;
  assign wr_word   = {in_sr[REG_W-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_CMD;
      bit_cnt   <= '0;
      len_q     <= CNT_W'(STAT_W);
      cmd_sr    <= '0;
      in_sr     <= '0;
      out_sr    <= '0;
      out_bit   <= 1'b1;
      waddr     <= '0;
      rd_data   <= 1'b0;
      cont_mode <= 1'b0;
      mode_q    <= '0;
      conf_q    <= '0;
    end else if (hit) begin
      st        <= ST_CMD;
      bit_cnt   <= '0;
      cmd_sr    <= '0;
      cont_mode <= 1'b0;
    end else begin
      if (fall && (st == ST_RD)) begin
        out_bit <= out_sr[FRAME_W-1];
        out_sr  <= {out_sr[FRAME_W-2:0], 1'b0};
      end
      if (exit_now) cont_mode <= 1'b0;

      case (st)
        ST_CMD: begin
          if (rise) begin
            cmd_sr <= cmd_byte;
            if (cmd_done) begin
              bit_cnt <= '0;
              if (start_rd) begin
                st      <= ST_RD;
                out_sr  <= rd_word;
                len_q   <= rd_len;
                out_bit <= 1'b0;
                rd_data <= (dec.addr == A_DATA);
                if ((dec.addr == A_DATA) && dec.cont) cont_mode <= 1'b1;
              end else if (start_wr) begin
                st    <= ST_WR;
                waddr <= dec.addr;
                len_q <= CNT_W'(REG_W);
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_WR: begin
          if (rise) begin
            in_sr <= wr_word;
            if (last_bit) begin
              st      <= ST_CMD;
              bit_cnt <= '0;
              if (waddr == A_MODE) mode_q <= wr_word;
              else                 conf_q <= wr_word;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RD: begin
          if (rise) begin
            cmd_sr <= cmd_byte;
            if (last_bit) begin
              bit_cnt <= '0;
              st      <= (cont_mode && !exit_now) ? ST_CWAIT : ST_CMD;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_CWAIT: begin
          if (cont_load) begin
            st      <= ST_RD;
            out_sr  <= rd_word;
            len_q   <= rd_len;
            out_bit <= 1'b0;
            rd_data <= 1'b1;
            bit_cnt <= '0;
          end
        end
        default: st <= ST_CMD;
      endcase
    end
  end

  assign dout_rdy = (st == ST_RD) ? out_bit : rdy_n;
  assign dout_oe  = act;

endmodule

// File: rtl/sri_serial_regif_chk.sv
module sri_serial_regif_chk #(
  parameter int CNT_W   = 6,
  parameter int FRAME_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             dout_oe,
  input logic             dout_rdy,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic [CNT_W-1:0] bit_cnt
);

  // R11: two cycles after a deselect sample the line is not driven
  assert_deselect_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) |-> !dout_oe);

  // R5: the cycle after a handshake the idle line shows not-ready
  assert_stage_rdy_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> (dout_rdy || !dout_oe));

  // R4: one word per handshake, never two back to back
  assert_single_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> !upd_ready);

  // R2: the bit position never passes the longest frame
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(FRAME_W));

endmodule

bind sri_serial_regif sri_serial_regif_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .dout_oe  (dout_oe),
  .dout_rdy (dout_rdy),
  .upd_valid(upd_valid),
  .upd_ready(upd_ready),
  .bit_cnt  (bit_cnt)
);

// File: tb/sri_serial_regif_tb.sv
`timescale 1ns/1ps
module sri_serial_regif_tb;

  localparam int HALF     = 6;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic        dout_rdy;
  logic        dout_oe;
  logic        upd_valid = 1'b0;
  logic [23:0] upd_data = '0;
  logic [2:0]  upd_chan = '0;
  logic        upd_ready;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sri_serial_regif u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .din      (din),
    .dout_rdy (dout_rdy),
    .dout_oe  (dout_oe),
    .upd_valid(upd_valid),
    .upd_data (upd_data),
    .upd_chan (upd_chan),
    .upd_ready(upd_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic d, output logic q);
    @(negedge clk);
    sclk = 1'b0;
    din  = d;
    idle(HALF);
    q    = dout_rdy;
    sclk = 1'b1;
    idle(HALF);
  endtask

  task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
    logic q;
    rx = '0;
    for (int k = n - 1; k >= 0; k--) begin
      bit_io(tx[k], q);
      rx = {rx[30:0], q};
    end
  endtask

  function automatic logic [7:0] cmd(input logic rd, input logic [2:0] a, input logic cont);
    return {1'b0, rd, a, cont, 2'b00};
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [23:0] v);
    logic [31:0] r;
    xfer({24'h0, cmd(1'b0, a, 1'b0)}, 8, r);
    xfer({8'h0, v}, 24, r);
  endtask

  task automatic rd_reg(input logic [2:0] a, input int n, output logic [31:0] v);
    logic [31:0] r;
    xfer({24'h0, cmd(1'b1, a, 1'b0)}, 8, r);
    xfer(32'h0, n, v);
  endtask

  // returns with the negedge just after the accepting edge
  task automatic push(input logic [23:0] d, input logic [2:0] c);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_data  = d;
    upd_chan  = c;
    while (!upd_ready) @(negedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [23:0] v;
    logic [2:0]  a;
    idle(5);
    rst_n = 1'b1;
    idle(3);

    // R1 / R11 reset state, deselected
    chk("R11 oe low while deselected", {31'h0, dout_oe}, 32'h0);
    chk("R1 update ready after reset", {31'h0, upd_ready}, 32'h1);
    cs_n = 1'b0;
    idle(5);
    chk("R1 line high with no word", {31'h0, dout_rdy}, 32'h1);
    chk("R11 oe high while selected", {31'h0, dout_oe}, 32'h1);
    rd_reg(A_MODE_C, 24, r);
    chk("R2 mode reset value", r, 32'h0);

    // R2 sweep of write/readback on mode and configuration
    for (int i = 0; i < 12; i++) begin
      v = (24'h1 << (2 * i)) ^ (24'hA5C3E1 >> i) ^ (24'(i) * 24'h010203);
      a = (i % 2 == 0) ? 3'd1 : 3'd2;
      wr_reg(a, v);
      rd_reg(a, 24, r);
      chk("R2 register readback", r, {8'h0, v});
    end
    wr_reg(3'd1, 24'h123446);
    wr_reg(3'd2, 24'h0F00F0);

    // R12 write to data dropped, R3 invalid command dropped
    xfer({24'h0, cmd(1'b0, 3'd3, 1'b0)}, 8, r);
    xfer(32'hC8, 8, r);
    rd_reg(3'd1, 24, r);
    chk("R12 R3 mode intact after dropped commands", r, 32'h123446);
    xfer({24'h0, cmd(1'b0, 3'd6, 1'b0)}, 8, r);
    rd_reg(3'd2, 24, r);
    chk("R12 config intact after write to addr 6", r, 32'h0F00F0);
    rd_reg(3'd5, 8, r);
    chk("R12 addr 5 reads zero byte", r, 32'h0);

    // R8 status before any update
    rd_reg(3'd0, 8, r);
    chk("R8 status with no word", r, 32'h80);

    wr_reg(3'd1, 24'h000000);
    // R4 / R8 sweep over channel tags
    for (int c = 0; c < 8; c++) begin
      v = 24'hABCDEF ^ (24'(c) * 24'h111111);
      push(v, 3'(c));
      chk("R5 line high in stage cycle", {31'h0, dout_rdy}, 32'h1);
      @(negedge clk);
      chk("R4 line low with new word", {31'h0, dout_rdy}, 32'h0);
      rd_reg(3'd0, 8, r);
      chk("R8 status channel tag", r, {24'h0, 5'h0, 3'(c)});
      rd_reg(3'd3, 24, r);
      chk("R4 data word readback", r, {8'h0, v});
      idle(4);
      chk("R4 line high after data read", {31'h0, dout_rdy}, 32'h1);
    end

    // R5 second word while one unread
    push(24'h111111, 3'd1);
    idle(2);
    push(24'h222222, 3'd2);
    chk("R5 line high before overwrite", {31'h0, dout_rdy}, 32'h1);
    @(negedge clk);
    chk("R5 line low after overwrite", {31'h0, dout_rdy}, 32'h0);
    rd_reg(3'd3, 24, r);
    chk("R5 newest word read", r, 32'h222222);

    // R6 stall during a read
    push(24'h5A5A5A, 3'd4);
    xfer({24'h0, cmd(1'b1, 3'd3, 1'b0)}, 8, r);
    xfer(32'h0, 4, r);
    chk("R6 update port stalled mid read", {31'h0, upd_ready}, 32'h0);
    v = r[23:0];
    xfer(32'h0, 20, r);
    chk("R6 partial read data", {v[3:0], r[19:0]}, 32'h5A5A5A);
    idle(3);
    chk("R6 update port free after read", {31'h0, upd_ready}, 32'h1);

    // R7 status appended
    wr_reg(3'd1, 24'h000010);
    push(24'h13579B, 3'd3);
    idle(2);
    rd_reg(3'd3, 32, r);
    chk("R7 data plus status", r, 32'h13579B03);
    wr_reg(3'd1, 24'h000000);

    // R9 continuous read
    push(24'hC0FFEE, 3'd1);
    idle(2);
    xfer({24'h0, cmd(1'b1, 3'd3, 1'b1)}, 8, r);
    xfer(32'h0, 24, r);
    chk("R9 first continuous word", r, 32'hC0FFEE);
    idle(4);
    chk("R9 line high while waiting", {31'h0, dout_rdy}, 32'h1);
    push(24'h0BADF0, 3'd2);
    idle(4);
    chk("R9 line low with word pending", {31'h0, dout_rdy}, 32'h0);
    xfer(32'h0, 24, r);
    chk("R9 word without command", r, 32'h0BADF0);
    push(24'h7E57ED, 3'd3);
    idle(4);
    xfer({8'h0, 8'h58, 16'h0}, 24, r);
    chk("R9 word carrying exit byte", r, 32'h7E57ED);
    push(24'h314159, 3'd4);
    idle(4);
    rd_reg(3'd0, 8, r);
    chk("R9 command honoured after exit", r, 32'h04);
    rd_reg(3'd3, 24, r);
    chk("R9 word read by command", r, 32'h314159);

    // R10 ones run realigns framing
    wr_reg(3'd1, 24'h00A5C3);
    xfer(32'h0, 3, r);
    xfer(32'hFFFFFFFF, 32, r);
    rd_reg(3'd1, 24, r);
    chk("R10 framing realigned by ones", r, 32'h00A5C3);

    // R11 deselected clocks ignored
    @(negedge clk);
    cs_n = 1'b1;
    idle(4);
    chk("R11 oe low when deselected", {31'h0, dout_oe}, 32'h0);
    wr_reg(3'd1, 24'hFFFF00);
    @(negedge clk);
    cs_n = 1'b0;
    idle(4);
    rd_reg(3'd1, 24, r);
    chk("R11 mode untouched by deselected clocks", r, 32'h00A5C3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [2:0] A_MODE_C = 3'd1;
  localparam logic [2:0] A_DATA_C = 3'd3;

  logic unused_tb;
  assign unused_tb = ^A_DATA_C;

endmodule